// File: doc/BRIEF.md
# Dual-Channel Gain Code Selector

This block works out the attenuation code and the power-on flag for each of the two channels of a dual variable-gain amplifier. A mode input picks the control source. In parallel mode a shared 7-bit code bus and a shutdown pin set both channels to the same state, and a new bus value takes effect without any register stage. In serial mode the contents of a register block reach the selector as parallel inputs: two attenuation values, a sync flag, two per-channel load flags and a power-control byte. Each channel then takes its own code and enable from these.

Each code step adds 0.25 dB of attenuation. Code 0 is maximum gain and code 80 is minimum gain. Any larger value is clamped to 80. Each channel has a hold register. It keeps the last code applied while the channel is off, so the channel comes back at the same gain when it is enabled again. After reset the hold registers contain 80.

Top module: `gain_code_sel`

## Requirements
- R1: `mode_serial_i` = 0 selects parallel control (bus and shutdown pin). `mode_serial_i` = 1 selects register control.
- R2: Each output code is an attenuation count in 0.25 dB steps. A code from 0 to 80 passes through unchanged, with bus bit k weighted 0.25·2^k dB.
- R3: A code above 80, from the bus or from either register, appears at the outputs as 80.
- R4: In parallel mode both channels always show the same code and the same enable. While the channels are on, a bus change appears at the outputs in the same cycle, before any clock edge.
- R5: In parallel mode `par_shdn_i` = 1 turns both enables off and 0 turns them on. In serial mode `par_shdn_i` has no effect.
- R6: While a channel is off, its code output stays at the last applied code. When the channel turns on again without a new load, that code is still shown.
- R7: In serial mode with `reg_sync_i` = 1, channel B takes the value of register A. With `reg_sync_i` = 0, channel B takes register B. Channel A always takes register A.
- R8: In serial mode an enabled channel copies its register at a clock edge only while its load flag is 1. The new code appears after that edge. With the load flag at 0 the channel code does not change.
- R9: In serial mode channel A is off when bit 5 or bit 3 of `reg_pwr_i` is 1, and channel B is off when bit 4 or bit 2 is 1. Bits 7, 6, 1 and 0 have no effect.
- R10: Synchronous reset sets both hold registers to 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_serial_i | input | 1 | 0 = parallel control, 1 = register control |
| par_code_i | input | 7 | Parallel attenuation code bus |
| par_shdn_i | input | 1 | Parallel shutdown, 1 = both channels off |
| reg_sync_i | input | 1 | Register sync flag, 1 = channel B follows register A |
| reg_load_a_i | input | 1 | Channel A load flag |
| reg_load_b_i | input | 1 | Channel B load flag |
| reg_atten_a_i | input | 7 | Attenuation register A |
| reg_atten_b_i | input | 7 | Attenuation register B |
| reg_pwr_i | input | 8 | Power-control register |
| code_a_o | output | 7 | Applied code, channel A |
| code_b_o | output | 7 | Applied code, channel B |
| en_a_o | output | 1 | Channel A power-on flag |
| en_b_o | output | 1 | Channel B power-on flag |

## Verification
The assertions check on every cycle that the outputs never exceed 80. They also check that the two channels match in parallel mode, that each enable follows the shutdown pin or the power-control bits, and that a code stays frozen while its channel is off or its load flag is low. They check the one-cycle register transfer as well, including the sync path. The bench scenarios cover the behaviours that depend on history or timing. These are: the reset value, a code restored after the channel is re-enabled, a parallel bus change seen before any clock edge, and a shutdown pin that is ignored across a mode switch. The bench also runs the clamp on specific out-of-range patterns.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    localparam int GCS_CODE_W = 7;
    localparam int GCS_CODE_MAX = 80;
    localparam int GCS_PWR_W = 8;
    localparam int GCS_NUM_CH = 2;
    // power-control bit positions (decoded by the register map)
    localparam int GCS_A_OFF_HI = 5;
    localparam int GCS_A_OFF_LO = 3;
    localparam int GCS_B_OFF_HI = 4;
    localparam int GCS_B_OFF_LO = 2;

    typedef logic [GCS_CODE_W-1:0] gcode_t;

    typedef enum logic {
        CTL_PARALLEL = 1'b0,
        CTL_SERIAL   = 1'b1
    } ctl_mode_e;

    typedef struct packed {
        logic   en;
        logic   load;
        gcode_t par_code;
        gcode_t reg_code;
    } chan_req_t;

    function automatic gcode_t clamp_code(gcode_t c);
        return (c > gcode_t'(GCS_CODE_MAX)) ? gcode_t'(GCS_CODE_MAX) : c;
    endfunction
endpackage

// File: rtl/gcs_en_decode.sv
module gcs_en_decode
    import gcs_pkg::*;
(
    input  ctl_mode_e                mode,
    input  logic                     par_shdn,
    input  logic [GCS_PWR_W-1:0]     pwr,
    output logic [GCS_NUM_CH-1:0]    en
);
    genvar ch;
    generate
        for (ch = 0; ch < GCS_NUM_CH; ch++) begin : g_ch
            localparam int HI = (ch == 0) ? GCS_A_OFF_HI : GCS_B_OFF_HI;
            localparam int LO = (ch == 0) ? GCS_A_OFF_LO : GCS_B_OFF_LO;
            logic reg_off;
            assign reg_off = pwr[HI] | pwr[LO];
            always_comb begin
                if (mode == CTL_SERIAL) en[ch] = ~reg_off;
                else                    en[ch] = ~par_shdn;
            end
        end
    endgenerate
endmodule

// File: rtl/gcs_src_sel.sv
module gcs_src_sel
    import gcs_pkg::*;
(
    input  logic                     sync,
    input  logic [GCS_NUM_CH-1:0]    load,
    input  logic [GCS_NUM_CH-1:0]    en,
    input  gcode_t                   par_code,
    input  gcode_t                   reg_a,
    input  gcode_t                   reg_b,
    output chan_req_t [GCS_NUM_CH-1:0] req
);
    gcode_t par_clamped;
    assign par_clamped = clamp_code(par_code);

    genvar ch;
    generate
        for (ch = 0; ch < GCS_NUM_CH; ch++) begin : g_ch
            gcode_t raw;
            if (ch == 0) begin : g_a
                assign raw = reg_a;
            end else begin : g_b
                assign raw = sync ? reg_a : reg_b;
            end
            always_comb begin
                req[ch].en       = en[ch];
                req[ch].load     = load[ch];
                req[ch].par_code = par_clamped;
                req[ch].reg_code = clamp_code(raw);
            end
        end
    endgenerate
endmodule

// File: rtl/gcs_chan.sv
module gcs_chan
    import gcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_mode_e mode,
    input  chan_req_t req,
    output gcode_t    code
);
    gcode_t hold_q;
    logic   upd;
    gcode_t nxt;

    always_comb begin
        if (mode == CTL_SERIAL) begin
            upd = req.en & req.load;
            nxt = req.reg_code;
        end else begin
            upd = req.en;
            nxt = req.par_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      hold_q <= gcode_t'(GCS_CODE_MAX);
        else if (upd) hold_q <= nxt;
    end

    // parallel bus reaches the output with no register stage while on
    always_comb begin
        if (mode == CTL_PARALLEL && req.en) code = req.par_code;
        else                                 code = hold_q;
    end
endmodule

// File: rtl/gain_code_sel.sv
module gain_code_sel
    import gcs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_serial_i,
    input  logic [GCS_CODE_W-1:0]  par_code_i,
    input  logic                   par_shdn_i,
    input  logic                   reg_sync_i,
    input  logic                   reg_load_a_i,
    input  logic                   reg_load_b_i,
    input  logic [GCS_CODE_W-1:0]  reg_atten_a_i,
    input  logic [GCS_CODE_W-1:0]  reg_atten_b_i,
    input  logic [GCS_PWR_W-1:0]   reg_pwr_i,
    output logic [GCS_CODE_W-1:0]  code_a_o,
    output logic [GCS_CODE_W-1:0]  code_b_o,
    output logic                   en_a_o,
    output logic                   en_b_o
);
    ctl_mode_e                 mode;
    logic [GCS_NUM_CH-1:0]     en;
    chan_req_t [GCS_NUM_CH-1:0] req;
    gcode_t                    code [GCS_NUM_CH];

    assign mode = mode_serial_i ? CTL_SERIAL : CTL_PARALLEL;

    gcs_en_decode u_en (
        .mode     (mode),
        .par_shdn (par_shdn_i),
        .pwr      (reg_pwr_i),
        .en       (en)
    );

    gcs_src_sel u_sel (
        .sync     (reg_sync_i),
        .load     ({reg_load_b_i, reg_load_a_i}),
        .en       (en),
        .par_code (par_code_i),
        .reg_a    (reg_atten_a_i),
        .reg_b    (reg_atten_b_i),
        .req      (req)
    );

    genvar ch;
    generate
        for (ch = 0; ch < GCS_NUM_CH; ch++) begin : g_ch
            gcs_chan u_chan (
                .clk  (clk),
                .rst  (rst),
                .mode (mode),
                .req  (req[ch]),
                .code (code[ch])
            );
        end
    endgenerate

    assign code_a_o = code[0];
    assign code_b_o = code[1];
    assign en_a_o   = en[0];
    assign en_b_o   = en[1];
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker
    import gcs_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   mode_serial_i,
    input logic [GCS_CODE_W-1:0]  par_code_i,
    input logic                   par_shdn_i,
    input logic                   reg_sync_i,
    input logic                   reg_load_a_i,
    input logic                   reg_load_b_i,
    input logic [GCS_CODE_W-1:0]  reg_atten_a_i,
    input logic [GCS_CODE_W-1:0]  reg_atten_b_i,
    input logic [GCS_PWR_W-1:0]   reg_pwr_i,
    input logic [GCS_CODE_W-1:0]  code_a_o,
    input logic [GCS_CODE_W-1:0]  code_b_o,
    input logic                   en_a_o,
    input logic                   en_b_o
);
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (code_a_o <= GCS_CODE_MAX) && (code_b_o <= GCS_CODE_MAX)); // R3

    AST_PAR_MATCH: assert property (@(posedge clk) disable iff (rst)
        !mode_serial_i |-> (code_a_o == code_b_o) && (en_a_o == en_b_o)); // R4

    AST_PAR_SHDN: assert property (@(posedge clk) disable iff (rst)
        !mode_serial_i |-> (en_a_o == !par_shdn_i)); // R5

    AST_PWR_DECODE: assert property (@(posedge clk) disable iff (rst)
        mode_serial_i |-> (en_a_o == !(reg_pwr_i[5] | reg_pwr_i[3]))
                       && (en_b_o == !(reg_pwr_i[4] | reg_pwr_i[2]))); // R9

    AST_FREEZE_A: assert property (@(posedge clk) disable iff (rst)
        !en_a_o |=> (!en_a_o -> $stable(code_a_o))); // R6

    AST_FREEZE_B: assert property (@(posedge clk) disable iff (rst)
        !en_b_o |=> (!en_b_o -> $stable(code_b_o))); // R6

    AST_NOLOAD_A: assert property (@(posedge clk) disable iff (rst)
        (mode_serial_i && !reg_load_a_i) |=> (mode_serial_i -> $stable(code_a_o))); // R8

    AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
        (mode_serial_i && reg_load_a_i && en_a_o) |=>
        (mode_serial_i -> code_a_o == clamp_code($past(reg_atten_a_i)))); // R8

    AST_SYNC_B: assert property (@(posedge clk) disable iff (rst)
        (mode_serial_i && reg_sync_i && reg_load_b_i && en_b_o) |=>
        (mode_serial_i -> code_b_o == clamp_code($past(reg_atten_a_i)))); // R7

    AST_SEP_B: assert property (@(posedge clk) disable iff (rst)
        (mode_serial_i && !reg_sync_i && reg_load_b_i && en_b_o) |=>
        (mode_serial_i -> code_b_o == clamp_code($past(reg_atten_b_i)))); // R7
endmodule

bind gain_code_sel gcs_checker chk_i (.*);

// File: tb/gain_code_sel_tb.sv
module gain_code_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_serial_i, par_shdn_i, reg_sync_i, reg_load_a_i, reg_load_b_i;
    logic [6:0] par_code_i, reg_atten_a_i, reg_atten_b_i;
    logic [7:0] reg_pwr_i;
    logic [6:0] code_a_o, code_b_o;
    logic       en_a_o, en_b_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gain_code_sel dut_i (.*);

    // mode, pcode, shdn, sync, lda, ldb, rega, regb, pwr, en_a, en_b, exp_a, exp_b
    localparam int NV = 18;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 7'd0,   1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd0,  7'd0 },  // R2
        {1'b0, 7'd127, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd80, 7'd80},  // R3
        {1'b0, 7'd81,  1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd80, 7'd80},  // R3
        {1'b0, 7'd80,  1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd80, 7'd80},  // R2
        {1'b0, 7'd40,  1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd40, 7'd40},  // R4
        {1'b0, 7'd10,  1'b1, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b0, 1'b0, 7'd40, 7'd40},  // R5 R6
        {1'b0, 7'd10,  1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd10, 7'd10},  // R5
        {1'b1, 7'd10,  1'b1, 1'b0, 1'b1, 1'b1, 7'd20,  7'd30, 8'h00, 1'b1, 1'b1, 7'd20, 7'd30},  // R1 R5
        {1'b1, 7'd10,  1'b0, 1'b1, 1'b1, 1'b1, 7'd50,  7'd70, 8'h00, 1'b1, 1'b1, 7'd50, 7'd50},  // R7
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b0, 1'b0, 7'd5,   7'd6,  8'h00, 1'b1, 1'b1, 7'd50, 7'd50},  // R8
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b0, 7'd5,   7'd6,  8'h00, 1'b1, 1'b1, 7'd5,  7'd50},  // R8
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b1, 7'd60,  7'd61, 8'h20, 1'b0, 1'b1, 7'd5,  7'd61},  // R9
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b1, 7'd60,  7'd61, 8'h08, 1'b0, 1'b1, 7'd5,  7'd61},  // R9
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b0, 1'b0, 7'd60,  7'd61, 8'h00, 1'b1, 1'b1, 7'd5,  7'd61},  // R6
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b1, 7'd60,  7'd62, 8'h10, 1'b1, 1'b0, 7'd60, 7'd61},  // R9
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b1, 7'd60,  7'd62, 8'h04, 1'b1, 1'b0, 7'd60, 7'd61},  // R9
        {1'b1, 7'd10,  1'b0, 1'b0, 1'b1, 1'b1, 7'd100, 7'd62, 8'hC3, 1'b1, 1'b1, 7'd80, 7'd62},  // R9 R3
        {1'b0, 7'd3,   1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  8'h00, 1'b1, 1'b1, 7'd3,  7'd3 }   // R1
    };

    function automatic string row_req(int i);
        case (i)
            0, 3:   return "R2";
            1, 2:   return "R3";
            4:      return "R4";
            5:      return "R6";
            6:      return "R5";
            7:      return "R5";
            8:      return "R7";
            9, 10:  return "R8";
            13:     return "R6";
            16:     return "R9";
            17:     return "R1";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        mode_serial_i = 1'b1; par_code_i = '0; par_shdn_i = 1'b0;
        reg_sync_i = 1'b0; reg_load_a_i = 1'b0; reg_load_b_i = 1'b0;
        reg_atten_a_i = 7'd9; reg_atten_b_i = 7'd9; reg_pwr_i = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #2;
        // R10: reset leaves minimum gain in both hold registers
        chk("R10", "reset code_a", code_a_o, 80);
        chk("R10", "reset code_b", code_b_o, 80);
        chk("R9", "reset en_a", en_a_o, 1);
        chk("R9", "reset en_b", en_b_o, 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_serial_i = VEC[i][49];
            par_code_i    = VEC[i][48:42];
            par_shdn_i    = VEC[i][41];
            reg_sync_i    = VEC[i][40];
            reg_load_a_i  = VEC[i][39];
            reg_load_b_i  = VEC[i][38];
            reg_atten_a_i = VEC[i][37:31];
            reg_atten_b_i = VEC[i][30:24];
            reg_pwr_i     = VEC[i][23:16];
            @(posedge clk); #2;
            chk(row_req(i), $sformatf("row %0d en_a", i), en_a_o, VEC[i][15]);
            chk(row_req(i), $sformatf("row %0d en_b", i), en_b_o, VEC[i][14]);
            chk(row_req(i), $sformatf("row %0d code_a", i), code_a_o, VEC[i][13:7]);
            chk(row_req(i), $sformatf("row %0d code_b", i), code_b_o, VEC[i][6:0]);
        end

        // R4: parallel bus change visible before the next clock edge
        @(negedge clk);
        par_code_i = 7'd12;
        #1;
        chk("R4", "immediate code_a", code_a_o, 12);
        chk("R4", "immediate code_b", code_b_o, 12);
        par_code_i = 7'd90;
        #1;
        chk("R3", "immediate clamp", code_a_o, 80);

        // R5: shutdown pin has no effect in serial mode even with reg bits clear
        @(negedge clk);
        mode_serial_i = 1'b1; par_shdn_i = 1'b1; reg_pwr_i = 8'h00;
        reg_load_a_i = 1'b0; reg_load_b_i = 1'b0;
        #1;
        chk("R5", "serial ignores shdn en_a", en_a_o, 1);
        chk("R5", "serial ignores shdn en_b", en_b_o, 1);
        @(posedge clk); #2;
        chk("R8", "serial keeps last par code", code_a_o, 80);

        finish_run();
    end
endmodule